// File: doc/BRIEF.md
# Program Status Polling Read Logic

This block sits on the read side of a parallel flash model. While an internal program cycle runs, the stored array is not valid to read. During that time the block replaces part of each returned byte with two completion indicators, so that host software can wait for the cycle to finish by reading the device repeatedly. The two indicators are independent and are both present in every busy read. Bit 7 carries the inverse of bit 7 of the byte that was loaded last. Bit 6 changes value on every new read access. When the busy flag drops, bit 6 stops changing and reads return the true stored byte on all bits.

A read access exists only while chip enable and output enable are both low and write enable is high. There are no tristate drivers: a registered valid flag shows when the outputs would be driven, and the data outputs are held at zero while that flag is low. The busy flag comes from outside the block. A program cycle drives it, and so does a bare write that lacked the unlock sequence, so both cases produce polling reads. Each output is registered and appears one clock after the inputs that produce it.

Top module: `poll_read_top`

## Requirements
- R1: While `busy` is high, a read returns on `rd_data[7]` the inverse of `last_byte[7]`.
- R2: While `busy` is high, each new read access (a low-to-high change of the combined read condition) inverts the value returned on `rd_data[6]` compared with the previous busy access.
- R3: An access that is held open for several clocks is counted once. `rd_data[6]` stays constant for as long as the access remains open.
- R4: While `busy` is low, a read returns `arr_data` unchanged on all eight bits. The bit 6 indicator keeps its last value, and the next busy access inverts that frozen value.
- R5: `rd_valid` is high exactly one clock after a cycle in which `ce_n`=0, `oe_n`=0 and `we_n`=1, and low one clock after any other combination.
- R6: While `rd_valid` is low, `rd_data` is zero.
- R7: While `busy` is high, `rd_data[5:0]` equals `arr_data[5:0]` from the sampled cycle.
- R8: After reset `rd_valid` is 0 and `rd_data` is 0. The bit 6 indicator starts at 0, so the first busy access after reset returns 1 on bit 6.
- R9: An access that is opened by cycling `ce_n` while `oe_n` stays low counts as a new access in the same way as one opened by cycling `oe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| busy | input | 1 | High while a program cycle or its timing window is running |
| last_byte | input | 8 | Byte most recently loaded into the sector buffer |
| arr_data | input | 8 | Stored array byte at the current read address |
| rd_data | output | 8 | Registered read data, zero when not valid |
| rd_valid | output | 1 | Registered flag that marks the outputs as driven |

## Verification
The assertions check the rules that hold on every clock: the inverted bit 7 during busy reads, the true data when not busy, the zero data while disabled, the valid flag following the strobe combination, a single start pulse for each access, and a toggle that changes only on a busy access start. Only the bench scenarios can show that the toggle sequence matches across many accesses. They also show that the first value after reset is 1, that an access opened by chip enable is counted the same as one opened by output enable, and that the frozen value carries across an idle gap into a later busy period.

// File: rtl/poll_pkg.sv
package poll_pkg;
    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_OPEN = 1'b1
    } acc_phase_t;
endpackage

// File: rtl/poll_strobe.sv
module poll_strobe
    import poll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic rd_active,
    output logic rd_start
);
    typedef struct packed {
        acc_phase_t phase;
    } strobe_st_t;

    strobe_st_t st_d, st_q;

    always_comb begin
        rd_active = !ce_n && !oe_n && we_n;
        rd_start  = rd_active && (st_q.phase == ACC_IDLE);
        st_d      = st_q;
        st_d.phase = rd_active ? ACC_OPEN : ACC_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: ACC_IDLE};
        else        st_q <= st_d;
    end

    // Each access opens with exactly one start pulse.
    assert_single_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && rd_active) |=> !rd_start);
endmodule

// File: rtl/poll_toggle.sv
module poll_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic tog_now
);
    typedef struct packed {
        logic tog;
    } tog_st_t;

    tog_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        if (step) st_d.tog = !st_q.tog;
        tog_now  = st_d.tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{tog: 1'b0};
        else        st_q <= st_d;
    end

    assert_toggle_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (st_q.tog != $past(st_q.tog)));
    assert_toggle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(st_q.tog));
endmodule

// File: rtl/poll_read_top.sv
module poll_read_top #(
    parameter int DATA_W   = 8,
    parameter int STAT_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              busy,
    input  logic [DATA_W-1:0] last_byte,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam logic [DATA_W-1:0] ZERO_W = '0;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } out_st_t;

    out_st_t out_d, out_q;
    logic rd_active, rd_start, tog_now;

    poll_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .rd_active(rd_active),
        .rd_start (rd_start)
    );

    poll_toggle u_toggle (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (busy && rd_start),
        .tog_now(tog_now)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = rd_active;
        if (!rd_active) begin
            out_d.data = ZERO_W;
        end else if (busy) begin
            out_d.data           = arr_data;
            out_d.data[STAT_BIT] = !last_byte[STAT_BIT];
            out_d.data[TOG_BIT]  = tog_now;
        end else begin
            out_d.data = arr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{valid: 1'b0, data: ZERO_W};
        else        out_q <= out_d;
    end

    assign rd_data  = out_q.data;
    assign rd_valid = out_q.valid;

    assert_status_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n && busy) |=> (rd_data[STAT_BIT] == !$past(last_byte[STAT_BIT])));
    assert_true_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n && !busy) |=> (rd_data == $past(arr_data)));
    assert_valid_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n) |=> rd_valid);
    assert_valid_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ce_n && !oe_n && we_n) |=> !rd_valid);
    assert_quiet_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == ZERO_W));
endmodule

// File: tb/poll_read_top_test.sv
module poll_read_top_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
    logic [7:0] last_byte = 8'h00, arr_data = 8'h00;
    logic [7:0] rd_data;
    logic rd_valid;
    int checks = 0, errors = 0;
    logic exp_tog = 1'b0;

    always #5 clk = ~clk;

    poll_read_top uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .busy(busy), .last_byte(last_byte), .arr_data(arr_data),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_byte();
        if (busy) return {~last_byte[7], exp_tog, arr_data[5:0]};
        return arr_data;
    endfunction

    // One access: open, observe (held for extra cycles), close via CE or OE.
    task automatic access(input bit via_ce, input int hold, input string req);
        logic [7:0] e;
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        if (busy) exp_tog = ~exp_tog;
        e = expect_byte();
        @(negedge clk);
        chk(rd_valid && rd_data == e, req, {rd_valid, rd_data}, {1'b1, e});
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(rd_valid && rd_data == e, "R3 held access", {rd_valid, rd_data}, {1'b1, e});
        end
        if (via_ce) ce_n = 1'b1; else oe_n = 1'b1;
        @(negedge clk);
        chk(!rd_valid && rd_data == 8'h00, "R6 closed access", {rd_valid, rd_data}, 9'h000);
    endtask

    task automatic t_reset();
        chk(!rd_valid && rd_data == 8'h00, "R8 reset state", {rd_valid, rd_data}, 9'h000);
    endtask

    task automatic t_busy_status();
        busy = 1'b1; last_byte = 8'h5A; arr_data = 8'hC3;
        access(1'b0, 0, "R8 first busy read bit6=1");
        last_byte = 8'hA5; arr_data = 8'h3C;
        access(1'b0, 0, "R2 R1 second busy read");
        last_byte = 8'h80; arr_data = 8'h15;
        access(1'b0, 0, "R7 busy low bits");
    endtask

    task automatic t_held();
        last_byte = 8'h01; arr_data = 8'h2A;
        access(1'b0, 4, "R3 held open");
        access(1'b0, 0, "R2 after held");
    endtask

    task automatic t_ce_cycle();
        last_byte = 8'hFF; arr_data = 8'h07;
        access(1'b1, 0, "R9 ce cycled 1");
        access(1'b1, 0, "R9 ce cycled 2");
        @(negedge clk); oe_n = 1'b1;
    endtask

    task automatic t_complete();
        busy = 1'b0; arr_data = 8'hB6; last_byte = 8'h00;
        access(1'b0, 0, "R4 true data");
        arr_data = 8'h41;
        access(1'b1, 1, "R4 true data ce");
        @(negedge clk); oe_n = 1'b1;
        busy = 1'b1; last_byte = 8'h7F; arr_data = 8'h00;
        access(1'b0, 0, "R4 toggle resumes from frozen");
        busy = 1'b0;
    endtask

    task automatic t_disabled();
        arr_data = 8'hEE;
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        chk(!rd_valid && rd_data == 8'h00, "R5 we low blocks read", {rd_valid, rd_data}, 9'h000);
        ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        chk(!rd_valid && rd_data == 8'h00, "R5 ce high blocks read", {rd_valid, rd_data}, 9'h000);
        ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        chk(!rd_valid && rd_data == 8'h00, "R5 oe high blocks read", {rd_valid, rd_data}, 9'h000);
        ce_n = 1'b1;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_busy_status();
        t_held();
        t_ce_cycle();
        t_complete();
        t_disabled();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule